// File: doc/BRIEF.md
# Receive Frame Address Filter

This block sits in an infrared link receiver between the frame deframer and the receive buffer. The deframer hands it a byte stream framed by start and end markers. The filter treats the first byte after a start marker as the frame's address byte. It then decides, once per frame, whether the bytes of that frame reach the buffer's write port or are thrown away.

When address matching is switched off, every frame goes through. When matching is on, a frame is kept if its address equals the programmed station value or the broadcast value 0xFF. Any other frame is discarded as a whole, including its trailing check bytes, and the filter goes back to waiting for the next start marker. The enable and station value are captured when a frame starts, so register writes made during a frame take effect only from the next frame. An end marker or a flush request returns the filter to its hunting state.

Top module: `rx_addr_filter`

## Requirements
- R1: While reset is asserted and in the first cycle after it, out_wr and out_eof are 0. A reset in the middle of a frame leaves the filter hunting, so bytes that follow without a new start marker are not written.
- R2: With matching on and an address byte equal to the captured station value, every byte of the frame is written in arrival order, starting with the address byte.
- R3: With matching on, a frame whose address byte is 0xFF is accepted whatever the station value is.
- R4: With matching on and an address that is neither the station value nor 0xFF, no byte of that frame is written, check bytes included, and no out_eof pulse is produced.
- R5: After a discarded frame, the next start marker begins a fresh decision, so a matching frame that follows immediately is fully written.
- R6: With matching off, every frame is written whatever its address byte is.
- R7: match_en and match_val are captured on the start marker. Changes made after that marker, even before the address byte arrives, do not affect the current frame.
- R8: After an end marker, bytes that arrive without a new start marker are not written.
- R9: A rx_flush pulse ends the current frame at once. No later byte of that frame is written, and its end marker produces no out_eof.
- R10: out_eof pulses for one cycle, one cycle after the end marker of an accepted frame.
- R11: A byte that is written appears on out_data with out_wr high exactly one clock after the cycle in which in_valid carried it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_flush | input | 1 | Abandon the current frame and hunt again |
| match_en | input | 1 | 1 = filter on address, 0 = accept all frames |
| match_val | input | W | Station address to compare against |
| in_sof | input | 1 | Start-of-frame marker, carries no byte |
| in_eof | input | 1 | End-of-frame marker, carries no byte |
| in_valid | input | 1 | in_data holds a frame byte this cycle |
| in_data | input | W | Frame byte from the deframer |
| out_wr | output | 1 | Write strobe toward the receive buffer |
| out_data | output | W | Byte to store when out_wr is high |
| out_eof | output | 1 | End of an accepted frame |

## Verification
The assertions assume that the deframer never raises in_sof, in_eof and in_valid in the same cycle. They also assume that rx_flush is a short pulse driven from the same clock domain. Given those inputs, the priority of flush over start over end over data decides every cycle without ambiguity. The stimulus drives at most one of the three stream signals per cycle, changes all inputs on the falling edge, and changes match_en and match_val only between markers.

// File: rtl/rxaf_pkg.sv
package rxaf_pkg;
   typedef enum logic [1:0] {
      ST_HUNT = 2'd0,
      ST_ADDR = 2'd1,
      ST_PASS = 2'd2,
      ST_DROP = 2'd3
   } rxaf_state_e;
endpackage

// File: rtl/rxaf_cmp.sv
module rxaf_cmp #(
   parameter int          W         = 8,
   parameter bit          BCAST_EN  = 1'b1,
   parameter logic [W-1:0] BCAST_VAL = '1
) (
   input  logic [W-1:0] addr,
   input  logic         en,
   input  logic [W-1:0] station,
   output logic         hit
);
   logic own_hit;
   logic bc_hit;

   assign own_hit = (addr == station);

   generate
      if (BCAST_EN) begin : g_bcast
         assign bc_hit = (addr == BCAST_VAL);
      end else begin : g_nobcast
         assign bc_hit = 1'b0;
      end
   endgenerate

   assign hit = !en || own_hit || bc_hit;
endmodule

// File: rtl/rxaf_ctrl.sv
module rxaf_ctrl
   import rxaf_pkg::*;
#(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         flush,
   input  logic         sof,
   input  logic         eof,
   input  logic         valid,
   input  logic         match_en,
   input  logic [W-1:0] match_val,
   input  logic         hit,
   output logic         en_q,
   output logic [W-1:0] val_q,
   output rxaf_state_e  state,
   output logic         wr_en,
   output logic         eof_acc
);
   rxaf_state_e nxt;
   logic        byte_beat;

   assign byte_beat = valid && !flush && !sof && !eof;

   always_comb begin
      nxt = state;
      if (flush)
         nxt = ST_HUNT;
      else if (sof)
         nxt = ST_ADDR;
      else if (eof)
         nxt = ST_HUNT;
      else if (valid && state == ST_ADDR)
         nxt = hit ? ST_PASS : ST_DROP;
   end

   assign wr_en   = byte_beat &&
                    (state == ST_PASS || (state == ST_ADDR && hit));
   assign eof_acc = eof && !flush && !sof && state == ST_PASS;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state <= ST_HUNT;
         en_q  <= 1'b0;
         val_q <= '0;
      end else begin
         state <= nxt;
         if (sof && !flush) begin
            en_q  <= match_en;
            val_q <= match_val;
         end
      end
   end

   // R7: captured settings only move on a start marker
   a_r7_settings_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !sof |=> ($stable(en_q) && $stable(val_q)));
endmodule

// File: rtl/rxaf_out.sv
module rxaf_out #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         wr_en,
   input  logic         eof_acc,
   input  logic [W-1:0] data,
   output logic         out_wr,
   output logic         out_eof,
   output logic [W-1:0] out_data
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_wr   <= 1'b0;
         out_eof  <= 1'b0;
         out_data <= '0;
      end else begin
         out_wr  <= wr_en;
         out_eof <= eof_acc;
         if (wr_en)
            out_data <= data;
      end
   end
endmodule

// File: rtl/rx_addr_filter.sv
module rx_addr_filter
   import rxaf_pkg::*;
#(
   parameter int           W         = 8,
   parameter bit           BCAST_EN  = 1'b1,
   parameter logic [W-1:0] BCAST_VAL = '1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         rx_flush,
   input  logic         match_en,
   input  logic [W-1:0] match_val,
   input  logic         in_sof,
   input  logic         in_eof,
   input  logic         in_valid,
   input  logic [W-1:0] in_data,
   output logic         out_wr,
   output logic [W-1:0] out_data,
   output logic         out_eof
);
   generate
      if (W < 1) begin : g_bad_width
         $error("rx_addr_filter: W must be at least 1");
      end
   endgenerate

   logic         en_q;
   logic [W-1:0] val_q;
   logic         hit;
   logic         wr_en;
   logic         eof_acc;
   rxaf_state_e  state;

   rxaf_cmp #(.W(W), .BCAST_EN(BCAST_EN), .BCAST_VAL(BCAST_VAL)) u_cmp (
      .addr    (in_data),
      .en      (en_q),
      .station (val_q),
      .hit     (hit)
   );

   rxaf_ctrl #(.W(W)) u_ctrl (
      .clk       (clk),
      .rst_n     (rst_n),
      .flush     (rx_flush),
      .sof       (in_sof),
      .eof       (in_eof),
      .valid     (in_valid),
      .match_en  (match_en),
      .match_val (match_val),
      .hit       (hit),
      .en_q      (en_q),
      .val_q     (val_q),
      .state     (state),
      .wr_en     (wr_en),
      .eof_acc   (eof_acc)
   );

   rxaf_out #(.W(W)) u_out (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (wr_en),
      .eof_acc  (eof_acc),
      .data     (in_data),
      .out_wr   (out_wr),
      .out_eof  (out_eof),
      .out_data (out_data)
   );

   // R4: a discarded frame writes nothing
   a_r4_drop_silent: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_DROP && in_valid && !in_sof && !rx_flush) |=> !out_wr);

   // R8: hunting ignores stray bytes
   a_r8_hunt_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_HUNT && !in_sof) |=> !out_wr);

   // R9: flush silences the next cycle
   a_r9_flush_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      rx_flush |=> (!out_wr && !out_eof));

   // R10: end pulse only follows an end marker
   a_r10_eof_source: assert property (@(posedge clk) disable iff (!rst_n)
      out_eof |-> $past(in_eof));

   // R11: every write traces to a byte one cycle earlier
   a_r11_wr_follows_valid: assert property (@(posedge clk) disable iff (!rst_n)
      out_wr |-> $past(in_valid));
endmodule

// File: tb/test_rx_addr_filter.sv
`timescale 1ns/100ps
module test_rx_addr_filter;
   logic       clk = 1'b0;
   logic       rst_n;
   logic       rx_flush;
   logic       match_en;
   logic [7:0] match_val;
   logic       in_sof, in_eof, in_valid;
   logic [7:0] in_data;
   logic       out_wr, out_eof;
   logic [7:0] out_data;

   int total = 0;
   int bad   = 0;
   logic [7:0] log_data [64];
   int log_cnt = 0;
   int eof_cnt = 0;

   always #2.5 clk = ~clk;

   rx_addr_filter i_rx_addr_filter (
      .clk(clk), .rst_n(rst_n), .rx_flush(rx_flush),
      .match_en(match_en), .match_val(match_val),
      .in_sof(in_sof), .in_eof(in_eof), .in_valid(in_valid), .in_data(in_data),
      .out_wr(out_wr), .out_data(out_data), .out_eof(out_eof)
   );

   always @(negedge clk) begin
      if (out_wr) begin
         if (log_cnt < 64) log_data[log_cnt] = out_data;
         log_cnt++;
      end
      if (out_eof) eof_cnt++;
   end

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic step(input logic s, input logic e, input logic v, input logic [7:0] d);
      in_sof = s; in_eof = e; in_valid = v; in_data = d;
      @(negedge clk);
   endtask

   task automatic idle(input int n);
      for (int k = 0; k < n; k++) step(0, 0, 0, 8'h00);
   endtask

   task automatic clear_log();
      log_cnt = 0;
      eof_cnt = 0;
   endtask

   task automatic frame(input logic [7:0] a);
      step(1, 0, 0, 8'h00);
      step(0, 0, 1, a);
      step(0, 0, 1, a ^ 8'h11);
      step(0, 0, 1, a + 8'd1);
      step(0, 0, 1, 8'hC3);
      step(0, 1, 0, 8'h00);
   endtask

   // fields: [17] enable, [16:9] station, [8:1] address, [0] accept
   localparam int NV = 8;
   localparam logic [17:0] VEC [NV] = '{
      {1'b1, 8'h5A, 8'h5A, 1'b1},
      {1'b1, 8'h5A, 8'h5B, 1'b0},
      {1'b1, 8'h5A, 8'hFF, 1'b1},
      {1'b0, 8'h5A, 8'h33, 1'b1},
      {1'b1, 8'h00, 8'h00, 1'b1},
      {1'b1, 8'hFF, 8'hFF, 1'b1},
      {1'b1, 8'h12, 8'h21, 1'b0},
      {1'b0, 8'h12, 8'hFF, 1'b1}
   };

   initial begin
      repeat (20000) @(posedge clk);
      total++; bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      rst_n = 1'b0; rx_flush = 1'b0; match_en = 1'b0; match_val = 8'h00;
      in_sof = 0; in_eof = 0; in_valid = 0; in_data = 8'h00;
      repeat (3) @(negedge clk);
      // R1: reset state
      chk(out_wr == 1'b0 && out_eof == 1'b0, "R1 reset outputs", {out_wr, out_eof}, 0);
      rst_n = 1'b1;
      idle(1);
      chk(out_wr == 1'b0 && out_eof == 1'b0, "R1 after reset", {out_wr, out_eof}, 0);

      // table walk: R2 R3 R4 R6
      for (int i = 0; i < NV; i++) begin
         logic [7:0] a;
         logic acc;
         int n;
         string tag;
         a   = VEC[i][8:1];
         acc = VEC[i][0];
         n   = acc ? 4 : 0;
         tag = !acc ? "R4" : (!VEC[i][17] ? "R6" : (a == 8'hFF ? "R3" : "R2"));
         match_en = VEC[i][17]; match_val = VEC[i][16:9];
         clear_log();
         frame(a);
         idle(2);
         chk(log_cnt == n, {tag, " write count"}, log_cnt, n);
         if (acc && log_cnt == 4) begin
            chk(log_data[0] == a,          {tag, " byte0"}, log_data[0], a);
            chk(log_data[1] == (a ^ 8'h11), {tag, " byte1"}, log_data[1], a ^ 8'h11);
            chk(log_data[2] == a + 8'd1,   {tag, " byte2"}, log_data[2], a + 8'd1);
            chk(log_data[3] == 8'hC3,      {tag, " byte3"}, log_data[3], 8'hC3);
         end
         chk(eof_cnt == (acc ? 1 : 0), {tag, " eof pulses R10"}, eof_cnt, acc ? 1 : 0);
      end

      // R5: dropped frame then matching frame back to back
      match_en = 1; match_val = 8'h44;
      clear_log();
      frame(8'h45);
      frame(8'h44);
      idle(2);
      chk(log_cnt == 4, "R5 frame after drop", log_cnt, 4);
      chk(log_cnt >= 1 && log_data[0] == 8'h44, "R5 first byte", log_data[0], 8'h44);

      // R7: settings changed after the start marker are ignored
      match_en = 1; match_val = 8'h40;
      clear_log();
      step(1, 0, 0, 8'h00);
      match_val = 8'h41; match_en = 0;
      step(0, 0, 1, 8'h41);
      step(0, 0, 1, 8'h99);
      step(0, 1, 0, 8'h00);
      idle(2);
      chk(log_cnt == 0, "R7 late change no accept", log_cnt, 0);
      match_en = 0;
      clear_log();
      step(1, 0, 0, 8'h00);
      match_en = 1; match_val = 8'h10;
      step(0, 0, 1, 8'h77);
      step(0, 0, 1, 8'h78);
      step(0, 1, 0, 8'h00);
      idle(2);
      chk(log_cnt == 2, "R7 late enable ignored", log_cnt, 2);

      // R8: bytes after end marker without a new start
      match_en = 0;
      frame(8'h01);
      clear_log();
      step(0, 0, 1, 8'hAA);
      step(0, 0, 1, 8'hBB);
      idle(2);
      chk(log_cnt == 0, "R8 stray bytes", log_cnt, 0);

      // R11: one-cycle latency
      step(1, 0, 0, 8'h00);
      step(0, 0, 1, 8'h3C);
      chk(out_wr == 1'b1 && out_data == 8'h3C, "R11 latency data", out_data, 8'h3C);
      step(0, 0, 0, 8'h00);
      chk(out_wr == 1'b0, "R11 strobe single", out_wr, 0);
      step(0, 1, 0, 8'h00);
      chk(out_eof == 1'b1, "R10 eof timing", out_eof, 1);
      idle(1);
      chk(out_eof == 1'b0, "R10 eof one cycle", out_eof, 0);

      // R9: flush in mid-frame
      match_en = 1; match_val = 8'h22;
      clear_log();
      step(1, 0, 0, 8'h00);
      step(0, 0, 1, 8'h22);
      step(0, 0, 1, 8'h23);
      rx_flush = 1; step(0, 0, 0, 8'h00); rx_flush = 0;
      step(0, 0, 1, 8'h24);
      step(0, 1, 0, 8'h00);
      idle(2);
      chk(log_cnt == 2, "R9 writes before flush", log_cnt, 2);
      chk(eof_cnt == 0, "R9 no eof after flush", eof_cnt, 0);

      // R1: reset in mid-frame
      match_en = 0;
      clear_log();
      step(1, 0, 0, 8'h00);
      step(0, 0, 1, 8'h50);
      rst_n = 0; step(0, 0, 0, 8'h00); rst_n = 1;
      step(0, 0, 1, 8'h51);
      step(0, 1, 0, 8'h00);
      idle(2);
      chk(log_cnt == 1, "R1 reset drops frame", log_cnt, 1);
      chk(eof_cnt == 0, "R1 no eof after reset", eof_cnt, 0);

      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule